// File: doc/BRIEF.md
# Instruction-Boundary Event Gate

This block sits next to a simple in-order CPU core and decides, at every instruction boundary, which pending event the core may take: a page fault, a protection fault, a debug fault, a single-step trap, a non-maskable interrupt or a maskable interrupt. The core pulses `bnd_valid` each time an instruction (or a single iteration of a repeated string operation) retires. Alongside the pulse it reports what the retiring instruction did to the masking state. The block answers one cycle later with a registered one-hot `take` vector.

The block owns four pieces of masking state. The interrupt-enable flag gates maskable interrupts. The resume flag stops a debug fault from firing again on a restarted instruction. An NMI-in-service bit blocks nested NMIs until a return-from-interrupt. A one-deep latch holds an NMI edge that arrived while NMIs were masked. A retiring stack-segment load opens a one-boundary window in which only page and protection faults can be taken. Choosing vectors and keeping the rest of the flag word are left to the core.

Top module: `boundary_event_gate`

## Requirements
- R1: After synchronous reset, `take`, `if_flag`, `rf_flag` and `nmi_busy` are all 0.
- R2: `take` has at most one bit set. It is nonzero only in the cycle after a cycle with `bnd_valid`=1. Each boundary strobe, including each string-iteration strobe, is evaluated on its own.
- R3: Bit positions and priority are fixed. Bit 0 is page fault, bit 1 protection fault, bit 2 debug fault, bit 3 single-step, bit 4 NMI and bit 5 INTR. When several events are allowed at one boundary, the lowest-numbered bit wins.
- R4: INTR (bit 5) is taken only if the interrupt-enable flag, after the retiring instruction's update, is 1. `intr_req` is sampled only at the boundary and is never remembered.
- R5: A clear-enable or set-enable retire changes the interrupt-enable flag only when `cpl` <= `iopl`. When `cpl` > `iopl`, the flag is left unchanged and the protection fault bit (bit 1) is requested at that boundary.
- R6: A flags-load retire writes the interrupt-enable flag from `ret_ld_if`, which holds bit 9 of the loaded flags word. An interrupt-gate entry clears the flag and overrides every other update. Flag changes apply to the same boundary's INTR decision.
- R7: Taking an NMI sets `nmi_busy`. It stays set until a boundary whose retiring instruction is a return-from-interrupt. At that boundary a pending NMI may already be taken again.
- R8: A rising edge on `nmi_req` is latched as pending, one deep. It stays pending until the NMI is taken, so a masked NMI is taken at the first boundary that allows it.
- R9: While `rf_flag` is 1 a debug fault is not taken. `restart_rf` sets `rf_flag`. A boundary that takes no page, protection or debug fault clears it, and `restart_rf` wins over the clear.
- R10: At a boundary whose retiring instruction loaded the stack segment, debug fault, single-step, NMI and INTR are all suppressed, while page and protection faults are still taken. The suppression covers only that boundary, and each further stack-segment load re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_valid | input | 1 | Instruction boundary / retire strobe |
| ret_clr_en | input | 1 | Retiring instruction clears interrupt enable |
| ret_set_en | input | 1 | Retiring instruction sets interrupt enable |
| ret_flags_ld | input | 1 | Retiring instruction loads the flags word |
| ret_ld_if | input | 1 | Enable bit (bit 9) of the loaded flags word |
| ret_iret | input | 1 | Retiring instruction is a return-from-interrupt |
| ret_ss_ld | input | 1 | Retiring instruction loaded the stack segment |
| ret_gate_entry | input | 1 | Handler entered through an interrupt gate |
| restart_rf | input | 1 | Core restarts a faulted instruction; sets resume flag |
| cpl | input | PL_W | Current privilege level |
| iopl | input | PL_W | I/O privilege level |
| nmi_req | input | 1 | Non-maskable interrupt request line |
| intr_req | input | 1 | Maskable interrupt request line (level) |
| dbg_fault_req | input | 1 | Debug fault request |
| step_req | input | 1 | Single-step trap request |
| pf_req | input | 1 | Page fault request |
| gp_req | input | 1 | Protection fault request |
| take | output | 6 | One-hot event taken at the previous boundary |
| if_flag | output | 1 | Interrupt-enable flag |
| rf_flag | output | 1 | Resume flag |
| nmi_busy | output | 1 | NMI handler in service |

## Verification
The embedded properties check several rules on every cycle. They cover the one-hot shape of `take` and the rule that nothing is taken without a boundary. They check that INTR is never taken with the enable flag low and never after a resume-flag-set cycle for a debug fault. They check that the stack-segment window never lets a maskable, debug or NMI event through, and that a privileged-violation boundary leaves the flag untouched. Other behaviours need sequences that only the bench's scenarios can build. These are the latching of an NMI edge during service and its release at the exact return boundary, INTR not being remembered across a disabled window, and the full priority chain. The bench compares every cycle against its own model under random stimulus and directed cases.

// File: rtl/beg_pkg.sv
package beg_pkg;
  localparam int EV_PF   = 0;
  localparam int EV_GP   = 1;
  localparam int EV_DBGF = 2;
  localparam int EV_STEP = 3;
  localparam int EV_NMI  = 4;
  localparam int EV_INTR = 5;
  localparam int NUM_EV  = 6;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  // events blocked in the boundary right after a stack-segment load
  localparam ev_vec_t SHADOW_BLOCK =
    ev_vec_t'((1 << EV_DBGF) | (1 << EV_STEP) | (1 << EV_NMI) | (1 << EV_INTR));
endpackage

// File: rtl/beg_flag_ctl.sv
module beg_flag_ctl #(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bnd,
  input  logic            clr_en,
  input  logic            set_en,
  input  logic            flags_ld,
  input  logic            ld_if,
  input  logic            gate_entry,
  input  logic            restart_rf,
  input  logic            commit_ok,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  output logic            if_next,
  output logic            priv_viol,
  output logic            if_q,
  output logic            rf_q
);
  logic priv_ok;

  assign priv_ok   = (cpl <= iopl);
  assign priv_viol = bnd & (clr_en | set_en) & ~priv_ok;

  always_comb begin
    if_next = if_q;
    if (bnd) begin
      if (gate_entry)              if_next = 1'b0;
      else if (flags_ld)           if_next = ld_if;
      else if (clr_en && priv_ok)  if_next = 1'b0;
      else if (set_en && priv_ok)  if_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_q <= 1'b0;
      rf_q <= 1'b0;
    end else begin
      if_q <= if_next;
      if (restart_rf)              rf_q <= 1'b1;
      else if (bnd && commit_ok)   rf_q <= 1'b0;
    end
  end

  AST_PRIV_KEEPS_IF: assert property (@(posedge clk) disable iff (rst)
    (bnd && (clr_en || set_en) && (cpl > iopl) && !flags_ld && !gate_entry)
      |=> $stable(if_q)); // R5
  AST_GATE_CLEARS_IF: assert property (@(posedge clk) disable iff (rst)
    (bnd && gate_entry) |=> !if_q); // R6
  AST_RESTART_SETS_RF: assert property (@(posedge clk) disable iff (rst)
    restart_rf |=> rf_q); // R9
endmodule

// File: rtl/beg_nmi_track.sv
module beg_nmi_track (
  input  logic clk,
  input  logic rst,
  input  logic bnd,
  input  logic iret,
  input  logic nmi_req,
  input  logic nmi_taken,
  output logic nmi_ready,
  output logic busy_q
);
  logic prev_q;
  logic pend_q;
  logic pend_eff;
  logic busy_eff;

  assign pend_eff  = pend_q | (nmi_req & ~prev_q);
  assign busy_eff  = busy_q & ~(bnd & iret);
  assign nmi_ready = pend_eff & ~busy_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= nmi_req;
      pend_q <= pend_eff & ~nmi_taken;
      if (bnd) busy_q <= nmi_taken | busy_eff;
    end
  end

  AST_NMI_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !(bnd && iret)) |=> busy_q); // R7
  AST_NMI_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !prev_q && !nmi_taken) |=> pend_q); // R8
endmodule

// File: rtl/beg_arbiter.sv
module beg_arbiter
  import beg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bnd,
  input  logic    shadow,
  input  ev_vec_t ev_raw,
  output ev_vec_t pick,
  output ev_vec_t take_q
);
  ev_vec_t ev_ok;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_mask
    assign ev_ok[g] = ev_raw[g] & ~(shadow & SHADOW_BLOCK[g]);
  end

  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (bnd && !found && ev_ok[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) take_q <= '0;
    else     take_q <= pick;
  end

  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_q)); // R2
  AST_NO_BOUNDARY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> (take_q == '0)); // R2
  AST_PF_WINS: assert property (@(posedge clk) disable iff (rst)
    (bnd && ev_raw[EV_PF]) |=> take_q[EV_PF]); // R3
  AST_SHADOW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (bnd && shadow) |=> ((take_q & SHADOW_BLOCK) == '0)); // R10
endmodule

// File: rtl/boundary_event_gate.sv
module boundary_event_gate
  import beg_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bnd_valid,
  input  logic              ret_clr_en,
  input  logic              ret_set_en,
  input  logic              ret_flags_ld,
  input  logic              ret_ld_if,
  input  logic              ret_iret,
  input  logic              ret_ss_ld,
  input  logic              ret_gate_entry,
  input  logic              restart_rf,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic              dbg_fault_req,
  input  logic              step_req,
  input  logic              pf_req,
  input  logic              gp_req,
  output logic [NUM_EV-1:0] take,
  output logic              if_flag,
  output logic              rf_flag,
  output logic              nmi_busy
);
  logic    if_next;
  logic    priv_viol;
  logic    nmi_ready;
  logic    commit_ok;
  ev_vec_t ev_raw;
  ev_vec_t pick;

  assign commit_ok = ~(pick[EV_PF] | pick[EV_GP] | pick[EV_DBGF]);

  beg_flag_ctl #(.PL_W(PL_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .bnd        (bnd_valid),
    .clr_en     (ret_clr_en),
    .set_en     (ret_set_en),
    .flags_ld   (ret_flags_ld),
    .ld_if      (ret_ld_if),
    .gate_entry (ret_gate_entry),
    .restart_rf (restart_rf),
    .commit_ok  (commit_ok),
    .cpl        (cpl),
    .iopl       (iopl),
    .if_next    (if_next),
    .priv_viol  (priv_viol),
    .if_q       (if_flag),
    .rf_q       (rf_flag)
  );

  beg_nmi_track u_nmi (
    .clk       (clk),
    .rst       (rst),
    .bnd       (bnd_valid),
    .iret      (ret_iret),
    .nmi_req   (nmi_req),
    .nmi_taken (pick[EV_NMI]),
    .nmi_ready (nmi_ready),
    .busy_q    (nmi_busy)
  );

  always_comb begin
    ev_raw          = '0;
    ev_raw[EV_PF]   = pf_req;
    ev_raw[EV_GP]   = gp_req | priv_viol;
    ev_raw[EV_DBGF] = dbg_fault_req & ~rf_flag;
    ev_raw[EV_STEP] = step_req;
    ev_raw[EV_NMI]  = nmi_ready;
    ev_raw[EV_INTR] = intr_req & if_next;
  end

  beg_arbiter u_arb (
    .clk    (clk),
    .rst    (rst),
    .bnd    (bnd_valid),
    .shadow (ret_ss_ld),
    .ev_raw (ev_raw),
    .pick   (pick),
    .take_q (take)
  );

  AST_INTR_NEEDS_IF: assert property (@(posedge clk) disable iff (rst)
    take[EV_INTR] |-> if_flag); // R4
  AST_NMI_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    take[EV_NMI] |-> nmi_busy); // R7
  AST_RF_BLOCKS_DBG: assert property (@(posedge clk) disable iff (rst)
    take[EV_DBGF] |-> !$past(rf_flag)); // R9
endmodule

// File: tb/tb_boundary_event_gate.sv
`timescale 1ns/1ps
module tb_boundary_event_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bnd_valid = 0, ret_clr_en = 0, ret_set_en = 0, ret_flags_ld = 0, ret_ld_if = 0;
  logic ret_iret = 0, ret_ss_ld = 0, ret_gate_entry = 0, restart_rf = 0;
  logic [1:0] cpl = 0, iopl = 0;
  logic nmi_req = 0, intr_req = 0, dbg_fault_req = 0, step_req = 0, pf_req = 0, gp_req = 0;
  logic [5:0] take;
  logic if_flag, rf_flag, nmi_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic m_if, m_rf, m_busy, m_pend, m_prev;

  always #5 clk = ~clk;

  boundary_event_gate #(.PL_W(2)) dut (
    .clk(clk), .rst(rst), .bnd_valid(bnd_valid),
    .ret_clr_en(ret_clr_en), .ret_set_en(ret_set_en), .ret_flags_ld(ret_flags_ld),
    .ret_ld_if(ret_ld_if), .ret_iret(ret_iret), .ret_ss_ld(ret_ss_ld),
    .ret_gate_entry(ret_gate_entry), .restart_rf(restart_rf),
    .cpl(cpl), .iopl(iopl), .nmi_req(nmi_req), .intr_req(intr_req),
    .dbg_fault_req(dbg_fault_req), .step_req(step_req), .pf_req(pf_req), .gp_req(gp_req),
    .take(take), .if_flag(if_flag), .rf_flag(rf_flag), .nmi_busy(nmi_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected decision computed from the requirements
  function automatic logic [5:0] model_pick(output logic ifn);
    logic ok, viol;
    logic [5:0] ev, pk;
    ok   = (cpl <= iopl);
    viol = (ret_clr_en | ret_set_en) & ~ok;
    ifn  = m_if;
    if (bnd_valid) begin
      if (ret_gate_entry)          ifn = 1'b0;   // R6
      else if (ret_flags_ld)       ifn = ret_ld_if;
      else if (ret_clr_en && ok)   ifn = 1'b0;   // R5
      else if (ret_set_en && ok)   ifn = 1'b1;
    end
    ev[0] = pf_req;
    ev[1] = gp_req | viol;
    ev[2] = dbg_fault_req & ~m_rf;
    ev[3] = step_req;
    ev[4] = (m_pend | (nmi_req & ~m_prev)) & ~(m_busy & ~ret_iret);
    ev[5] = intr_req & ifn;
    if (ret_ss_ld) ev[5:2] = 4'b0;              // R10
    pk = '0;
    if (bnd_valid) begin
      for (int i = 0; i < 6; i++) begin
        if (ev[i]) begin pk[i] = 1'b1; break; end
      end
    end
    return pk;
  endfunction

  task automatic cyc();
    logic ifn;
    logic [5:0] pk;
    logic pend_eff;
    pk = model_pick(ifn);
    pend_eff = m_pend | (nmi_req & ~m_prev);
    @(posedge clk);
    @(negedge clk);
    m_pend = pend_eff & ~pk[4];
    if (bnd_valid) m_busy = pk[4] | (m_busy & ~ret_iret);
    if (restart_rf) m_rf = 1'b1;
    else if (bnd_valid && !(pk[0] | pk[1] | pk[2])) m_rf = 1'b0;
    m_prev = nmi_req;
    m_if   = ifn;
    chk("R3 take", 32'(take), 32'(pk));
    chk("R6 if_flag", 32'(if_flag), 32'(m_if));
    chk("R9 rf_flag", 32'(rf_flag), 32'(m_rf));
    chk("R7 nmi_busy", 32'(nmi_busy), 32'(m_busy));
  endtask

  task automatic idle();
    bnd_valid = 0; ret_clr_en = 0; ret_set_en = 0; ret_flags_ld = 0; ret_ld_if = 0;
    ret_iret = 0; ret_ss_ld = 0; ret_gate_entry = 0; restart_rf = 0;
    nmi_req = 0; intr_req = 0; dbg_fault_req = 0; step_req = 0; pf_req = 0; gp_req = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_if = 0; m_rf = 0; m_busy = 0; m_pend = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 take", 32'(take), 0);
    chk("R1 if_flag", 32'(if_flag), 0);
    chk("R1 rf_flag", 32'(rf_flag), 0);
    chk("R1 nmi_busy", 32'(nmi_busy), 0);

    // R4: INTR masked, then set-enable opens the same boundary
    idle(); intr_req = 1; bnd_valid = 1; cyc();
    chk("R4 intr masked", 32'(take), 0);
    ret_set_en = 1; cyc();
    chk("R4 intr taken", 32'(take), 32'h20);
    chk("R4 if set", 32'(if_flag), 1);
    idle(); ret_clr_en = 1; intr_req = 1; bnd_valid = 1; cyc();
    chk("R4 intr after clear", 32'(take), 0);
    idle(); intr_req = 1; cyc();
    idle(); ret_set_en = 1; bnd_valid = 1; cyc();
    chk("R4 intr not latched", 32'(take), 0);

    // R5: privilege violation
    idle(); cpl = 3; iopl = 1; ret_clr_en = 1; bnd_valid = 1; cyc();
    chk("R5 gp on violation", 32'(take), 32'h02);
    chk("R5 if unchanged", 32'(if_flag), 1);
    cpl = 0; iopl = 0;

    // R6: flags load and gate entry
    idle(); ret_flags_ld = 1; ret_ld_if = 0; bnd_valid = 1; cyc();
    chk("R6 load 0", 32'(if_flag), 0);
    ret_ld_if = 1; cyc();
    chk("R6 load 1", 32'(if_flag), 1);
    ret_gate_entry = 1; cyc();
    chk("R6 gate clears", 32'(if_flag), 0);
    idle(); ret_set_en = 1; bnd_valid = 1; cyc();

    // R8 / R7: NMI latch and service blocking
    idle(); nmi_req = 1; cyc();
    chk("R2 no take off boundary", 32'(take), 0);
    idle(); bnd_valid = 1; cyc();
    chk("R8 latched nmi taken", 32'(take), 32'h10);
    chk("R7 busy set", 32'(nmi_busy), 1);
    idle(); nmi_req = 1; bnd_valid = 1; cyc();
    chk("R7 nested blocked", 32'(take), 0);
    idle(); bnd_valid = 1; cyc();
    chk("R7 still blocked", 32'(take), 0);
    idle(); ret_iret = 1; ret_flags_ld = 1; ret_ld_if = 1; bnd_valid = 1; cyc();
    chk("R7 pending taken at return", 32'(take), 32'h10);
    chk("R7 busy again", 32'(nmi_busy), 1);
    cyc();
    chk("R7 return clears busy", 32'(nmi_busy), 0);
    chk("R7 nothing left", 32'(take), 0);

    // R9: resume flag
    idle(); restart_rf = 1; cyc();
    chk("R9 rf set", 32'(rf_flag), 1);
    idle(); dbg_fault_req = 1; bnd_valid = 1; cyc();
    chk("R9 dbg blocked", 32'(take), 0);
    chk("R9 rf cleared", 32'(rf_flag), 0);
    cyc();
    chk("R9 dbg taken", 32'(take), 32'h04);

    // R10: stack-segment shadow
    idle(); ret_ss_ld = 1; intr_req = 1; step_req = 1; bnd_valid = 1; cyc();
    chk("R10 shadow blocks", 32'(take), 0);
    ret_ss_ld = 1; cyc();
    chk("R10 rearmed", 32'(take), 0);
    ret_ss_ld = 0; cyc();
    chk("R10 expires", 32'(take), 32'h08);
    idle(); ret_ss_ld = 1; gp_req = 1; intr_req = 1; bnd_valid = 1; cyc();
    chk("R10 gp passes", 32'(take), 32'h02);
    gp_req = 0; pf_req = 1; cyc();
    chk("R10 pf passes", 32'(take), 32'h01);
    idle(); intr_req = 1; bnd_valid = 1; cyc();
    chk("R10 intr after window", 32'(take), 32'h20);

    // R3 priority chain
    idle(); bnd_valid = 1; pf_req = 1; gp_req = 1; dbg_fault_req = 1; step_req = 1; intr_req = 1; cyc();
    chk("R3 pf first", 32'(take), 32'h01);
    pf_req = 0; cyc();
    chk("R3 gp second", 32'(take), 32'h02);
    gp_req = 0; cyc();
    chk("R3 dbg third", 32'(take), 32'h04);
    dbg_fault_req = 0; cyc();
    chk("R3 step fourth", 32'(take), 32'h08);

    // R2: nothing without a boundary
    bnd_valid = 0; pf_req = 1; gp_req = 1; cyc();
    chk("R2 idle boundary", 32'(take), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bnd_valid      = ($urandom_range(0, 99) < 60);
      ret_clr_en     = ($urandom_range(0, 99) < 10);
      ret_set_en     = ($urandom_range(0, 99) < 15);
      ret_flags_ld   = ($urandom_range(0, 99) < 10);
      ret_ld_if      = $urandom_range(0, 1);
      ret_iret       = ($urandom_range(0, 99) < 10);
      ret_ss_ld      = ($urandom_range(0, 99) < 20);
      ret_gate_entry = ($urandom_range(0, 99) < 5);
      restart_rf     = ($urandom_range(0, 99) < 8);
      cpl            = 2'($urandom_range(0, 3));
      iopl           = 2'($urandom_range(0, 3));
      nmi_req        = ($urandom_range(0, 99) < 15);
      intr_req       = ($urandom_range(0, 99) < 40);
      dbg_fault_req  = ($urandom_range(0, 99) < 15);
      step_req       = ($urandom_range(0, 99) < 10);
      pf_req         = ($urandom_range(0, 99) < 4);
      gp_req         = ($urandom_range(0, 99) < 4);
      cyc();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule